// File: doc/BRIEF.md
# Sigma-Delta Increment Accumulator

This block is the digital half of a first-order sigma-delta loop that integrates one inertial sensor axis. An external analog integrator feeds a comparator whose one-bit decision reaches this block on `cmp_in`. The block brings that bit into the clock domain, holds it for one period in a feedback flop and drives it out on `dac_ctrl` to steer the one-bit feedback DAC. The same feedback bit advances a free-running counter once for every period in which it is high. Because the loop keeps the analog integrator near zero, the count tracks the time integral of the sensor signal, which is an angle or velocity increment. One count stands for full-scale feedback level times one clock period.

The host never reads raw samples at a fixed rate. Whenever it needs an increment it pulses `read_req` for one cycle. One clock later the block raises `delta_valid` for a single cycle and presents on `delta_out` the number of high feedback periods since the previous request. The difference is taken modulo 2^CNT_W, so a counter wrap between two requests still yields the right increment. The result stream has no back-pressure: the host asks only when it is ready to accept, and `delta_out` stays unchanged until the next request, so a host that misses the one-cycle strobe can still read the value.

Top module: `sd_incr_accum`

## Requirements
- R1: `dac_ctrl` equals the value `cmp_in` had three rising edges earlier (two synchronizer stages plus the feedback flop). Each level is held for exactly one clock period, so a one-cycle pulse on `cmp_in` gives a one-cycle pulse on `dac_ctrl`.
- R2: The accumulation counter gains exactly one on each rising edge at which `dac_ctrl` is 1 and keeps its value otherwise. At the ports this is seen as each delta equalling the number of cycles with `dac_ctrl` high in its interval.
- R3: If `read_req` is 1 at a rising edge, `delta_valid` is 1 for exactly the following cycle. `delta_out` then equals the counter value before that edge minus the counter value latched at the previous request, or minus zero after reset.
- R4: Between requests, `delta_out` holds its value and `delta_valid` stays 0, whatever `cmp_in` does.
- R5: The counter wraps modulo 2^CNT_W. Any interval with fewer than 2^CNT_W high periods yields its exact count, even when the counter wraps inside it.
- R6: While `rst` (synchronous, active high) is 1 at a rising edge, the synchronizer, feedback bit, counter and previous-snapshot register are all cleared. The outputs read `dac_ctrl`=0, `delta_valid`=0 and `delta_out`=0, and the first delta after reset counts from zero.
- R7: In closed loop with an input between zero and full scale, constant or ramping, each delta differs from the ideal integral of the input over the same interval by no more than 10 counts. This bound does not depend on how long the interval runs.
- R8: Requests on consecutive cycles each return their own one-cycle interval, a value of 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Asynchronous comparator decision |
| read_req | input | 1 | One-cycle host request for an increment |
| dac_ctrl | output | 1 | Feedback DAC control: 1 selects full-scale feedback, 0 selects none |
| delta_valid | output | 1 | One-cycle strobe marking a fresh increment |
| delta_out | output | CNT_W | Increment since the previous request, modulo 2^CNT_W |

## Verification
The bench closes the loop with an integer model of the analog integrator. It drives constant inputs at zero, full scale and odd fractions, plus a ramp, and reads at intervals from one cycle to about a thousand. A design that dropped a count or added one at the interval boundary would fail the exact per-interval count. A design with the wrong feedback latency would skew both that count and the integral bound. A narrow instance is run through several counter wraps, which exposes a non-modular subtraction as a huge delta. The bench also fires a one-cycle comparator pulse, where a missing or extra synchronizer stage shows up as a shifted DAC pulse. A reset in mid-run exposes a previous-snapshot register that reset fails to clear, because the first delta after reset then comes out wrong.

// File: rtl/sdia_pkg.sv
package sdia_pkg;

  // Feedback DAC level chosen by the registered comparator decision.
  typedef enum logic {
    FB_ZERO = 1'b0,
    FB_FULL = 1'b1
  } fb_level_e;

endpackage

// File: rtl/sdia_sync.sv
module sdia_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sdia_loop_core.sv
module sdia_loop_core
  import sdia_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_sync,
  output fb_level_e        fb_lvl,
  output logic [CNT_W-1:0] count
);

  fb_level_e        fb_q;
  logic [CNT_W-1:0] count_q;

  // Feedback flop: holds the decision for one full period.
  always_ff @(posedge clk) begin
    if (rst) fb_q <= FB_ZERO;
    else     fb_q <= bit_sync ? FB_FULL : FB_ZERO;
  end

  // Free-running accumulator of high feedback periods, wraps naturally.
  always_ff @(posedge clk) begin
    if (rst)                 count_q <= '0;
    else if (fb_q == FB_FULL) count_q <= count_q + CNT_W'(1);
  end

  assign fb_lvl = fb_q;
  assign count  = count_q;

endmodule

// File: rtl/sdia_snap.sv
module sdia_snap #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             read_req,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] delta,
  output logic             valid
);

  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] delta_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      delta_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= read_req;
      if (read_req) begin
        prev_q  <= count;
        delta_q <= count - prev_q;  // modulo 2^CNT_W
      end
    end
  end

  assign delta = delta_q;
  assign valid = valid_q;

endmodule

// File: rtl/sd_incr_accum.sv
module sd_incr_accum
  import sdia_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_in,
  input  logic             read_req,
  output logic             dac_ctrl,
  output logic             delta_valid,
  output logic [CNT_W-1:0] delta_out
);

  logic             cmp_sync;
  fb_level_e        fb_lvl;
  logic [CNT_W-1:0] acc_count;

  sdia_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_in),
    .q   (cmp_sync)
  );

  sdia_loop_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .bit_sync (cmp_sync),
    .fb_lvl   (fb_lvl),
    .count    (acc_count)
  );

  sdia_snap #(.CNT_W(CNT_W)) u_snap (
    .clk      (clk),
    .rst      (rst),
    .read_req (read_req),
    .count    (acc_count),
    .delta    (delta_out),
    .valid    (delta_valid)
  );

  assign dac_ctrl = (fb_lvl == FB_FULL);

endmodule

// File: rtl/sd_incr_accum_chk.sv
module sd_incr_accum_chk #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cmp_in,
  input logic             read_req,
  input logic             dac_ctrl,
  input logic             delta_valid,
  input logic [CNT_W-1:0] delta_out,
  input logic [CNT_W-1:0] acc_count
);

  localparam int LAT = SYNC_STAGES + 1;
  localparam logic [CNT_W:0] LIM = {1'b0, {CNT_W{1'b1}}};

  logic [LAT-1:0] hist;
  logic [3:0]     cyc;
  logic [CNT_W:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      cyc  <= '0;
      gap  <= '0;
    end else begin
      hist <= {hist[LAT-2:0], cmp_in};
      if (cyc != 4'hf) cyc <= cyc + 4'd1;
      if (read_req)        gap <= {{CNT_W{1'b0}}, 1'b1};
      else if (gap != '1)  gap <= gap + 1'b1;
    end
  end

  AST_FB_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (32'(cyc) >= LAT) |-> (dac_ctrl == hist[LAT-1])); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 4'd1) |-> (acc_count == $past(acc_count) + CNT_W'($past(dac_ctrl)))); // R2

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 4'd1 && delta_valid) |-> $past(read_req)); // R3

  AST_DELTA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 4'd1 && !delta_valid) |-> $stable(delta_out)); // R4

  AST_DELTA_BOUND: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 4'd1 && delta_valid) |-> (($past(gap) > LIM) || ({1'b0, delta_out} <= $past(gap)))); // R7

endmodule

bind sd_incr_accum sd_incr_accum_chk #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmp_in      (cmp_in),
  .read_req    (read_req),
  .dac_ctrl    (dac_ctrl),
  .delta_valid (delta_valid),
  .delta_out   (delta_out),
  .acc_count   (acc_count)
);

// File: tb/sd_incr_accum_tb.sv
module sd_incr_accum_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_in = 1'b0;
  logic        read_req = 1'b0;
  logic        dac_ctrl;
  logic        delta_valid;
  logic [31:0] delta_out;

  logic        w_cmp = 1'b0;
  logic        w_req = 1'b0;
  logic        w_dac;
  logic        w_valid;
  logic [5:0]  w_delta;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // closed-loop model state (percent of full scale)
  int integ = 0;
  int acc   = 0;
  int isum  = 0;
  int wacc  = 0;

  always #2 clk = ~clk;

  sd_incr_accum u_dut (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .read_req(read_req),
    .dac_ctrl(dac_ctrl), .delta_valid(delta_valid), .delta_out(delta_out)
  );

  sd_incr_accum #(.CNT_W(6)) u_wrap (
    .clk(clk), .rst(rst), .cmp_in(w_cmp), .read_req(w_req),
    .dac_ctrl(w_dac), .delta_valid(w_valid), .delta_out(w_delta)
  );

  // {start level %, ramp slope % per 16 cycles, read period, reads}
  localparam int VEC [8][4] = '{
    '{50, 0, 200, 4},
    '{ 0, 0, 100, 2},
    '{100,0, 100, 2},
    '{13, 0, 997, 3},
    '{87, 0, 300, 3},
    '{ 5, 1, 150, 4},
    '{99, 0,   1, 10},
    '{33, 0,   2, 6}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // One cycle of the main loop; entered and left at a falling edge.
  task automatic dtick(input int vin, input bit req);
    int fb;
    int ex;
    int exi;
    ex = 0; exi = 0;
    fb = int'(dac_ctrl);
    integ += vin - fb * 100;
    cmp_in   = (integ > 0);
    read_req = req;
    if (req) begin
      ex = acc; exi = isum; acc = 0; isum = 0;
    end
    acc  += fb;
    isum += vin;
    @(posedge clk); @(negedge clk);
    read_req = 1'b0;
    if (req) begin
      chk(delta_valid == 1'b1, "R3", "delta_valid after request", delta_valid, 1);
      chk(delta_out == 32'(ex), "R2", "delta equals high feedback periods", delta_out, ex);
      chk((int'(delta_out) * 100 - exi <= 1000) && (exi - int'(delta_out) * 100 <= 1000),
          "R7", "delta vs ideal integral x100", int'(delta_out) * 100, exi);
    end
  endtask

  // One cycle of the narrow instance; entered and left at a falling edge.
  task automatic wtick(input bit c, input bit req);
    int fb;
    int ex;
    ex = 0;
    fb = int'(w_dac);
    w_cmp = c;
    w_req = req;
    if (req) begin
      ex = wacc; wacc = 0;
    end
    wacc += fb;
    @(posedge clk); @(negedge clk);
    w_req = 1'b0;
    if (req) begin
      chk(w_valid == 1'b1, "R3", "narrow delta_valid", w_valid, 1);
      chk(w_delta == 6'(ex), "R5", "narrow delta modulo 64", w_delta, ex & 63);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(1'b0, "WATCHDOG", "run did not finish", cycles, 150000);
        summary();
      end
    end
  end

  initial begin
    int held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R6: state right after reset
    chk(dac_ctrl == 1'b0, "R6", "dac_ctrl after reset", dac_ctrl, 0);
    chk(delta_valid == 1'b0, "R6", "delta_valid after reset", delta_valid, 0);
    chk(delta_out == 32'd0, "R6", "delta_out after reset", delta_out, 0);
    chk(w_delta == 6'd0, "R6", "narrow delta_out after reset", w_delta, 0);

    // Vector table: closed loop, R2 R3 R7, period 1 covers R8
    for (int v = 0; v < 8; v++) begin
      int t;
      t = 0;
      for (int r = 0; r < VEC[v][3]; r++) begin
        for (int c = 0; c < VEC[v][2]; c++) begin
          int vin;
          vin = VEC[v][0] + (t * VEC[v][1]) / 16;
          if (vin > 100) vin = 100;
          dtick(vin, c == VEC[v][2] - 1);
          t++;
        end
      end
    end

    // R4: delta held and strobe low between requests
    dtick(60, 1'b1);
    held = int'(delta_out);
    for (int k = 0; k < 25; k++) dtick(60, 1'b0);
    chk(delta_out == 32'(held), "R4", "delta_out held between requests", delta_out, held);
    chk(delta_valid == 1'b0, "R4", "delta_valid low between requests", delta_valid, 0);

    // R1: single-cycle comparator pulse reaches dac_ctrl after three edges
    wtick(1'b1, 1'b0);
    chk(w_dac == 1'b0, "R1", "dac after 1 edge", w_dac, 0);
    wtick(1'b0, 1'b0);
    chk(w_dac == 1'b0, "R1", "dac after 2 edges", w_dac, 0);
    wtick(1'b0, 1'b0);
    chk(w_dac == 1'b1, "R1", "dac after 3 edges", w_dac, 1);
    wtick(1'b0, 1'b0);
    chk(w_dac == 1'b0, "R1", "dac pulse lasts one period", w_dac, 0);

    // R5: several wraps of a 6-bit counter with 60-cycle intervals
    wtick(1'b1, 1'b1);
    for (int k = 0; k < 240; k++) wtick(1'b1, (k % 60) == 59);

    // R8: back-to-back requests on the narrow instance
    wtick(1'b1, 1'b1);
    wtick(1'b1, 1'b1);
    wtick(1'b1, 1'b1);
    chk(w_delta == 6'd1, "R8", "back-to-back delta at full scale", w_delta, 1);

    // R6: reset mid-run clears counter and previous snapshot
    for (int k = 0; k < 7; k++) wtick(1'b1, 1'b0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    wacc = 0;
    chk(w_dac == 1'b0, "R6", "narrow dac after mid-run reset", w_dac, 0);
    chk(w_delta == 6'd0, "R6", "narrow delta after mid-run reset", w_delta, 0);
    for (int k = 0; k < 10; k++) wtick(1'b1, 1'b0);
    wtick(1'b1, 1'b1);
    chk(w_delta == 6'd7, "R6", "first delta after reset counts from zero", w_delta, 7);

    summary();
  end

endmodule